// File: doc/BRIEF.md
# Quadrature Step Decoder

This block turns the two raw phase signals of an incremental encoder into a count-enable strobe and a direction level. Those two signals drive a plain up/down binary counter that sits outside the block. Both phase inputs are asynchronous. Each one passes through a short synchroniser. A history register then compares the current sampled pair against the pair from the previous clock.

The encoder state is written as the pair {B,A}. Forward motion walks 00 → 01 → 11 → 10 → 00. A static two-bit resolution input picks how many counts one full cycle produces: one, two or four. Every qualified step gives exactly one strobe cycle. The direction bit is valid in the same cycle.

Decoding is edge based. When only one phase chatters, each extra edge produces a strobe of the opposite sense, so the counter ends at the right value. A change on both phases within one sampled clock cannot be decoded. It raises an error pulse and gives no strobe.

Top module: `quad_step_decoder`

## Requirements
- R1: Each phase input passes through a two-stage synchroniser, and all outputs are registered. A single phase change held for at least one clock produces its output pulse within four clocks of the change, and exactly one such pulse.
- R2: In 4x resolution, every change of exactly one phase produces one cycle of `cnt_en`. `cnt_up` is 1 when the step follows the forward order {B,A} 00→01→11→10→00 and 0 for the reverse order.
- R3: In 2x resolution, only a change of A produces `cnt_en`. `cnt_up` equals A XOR B after the edge. A change of B alone produces nothing.
- R4: In 1x resolution, only a change of A while B is 0 produces `cnt_en`. A rising A counts up (`cnt_up`=1) and a falling A counts down. A change of A while B is 1, or any change of B alone, produces nothing.
- R5: The resolution encoding is: `res_sel` 2'b00 selects 1x, 2'b01 selects 2x, and both 2'b10 and 2'b11 select 4x.
- R6: When both phases change in the same sampled clock, `step_err` is high for one cycle and `cnt_en` stays low, in every resolution. `cnt_en` and `step_err` are never high together.
- R7: When one phase chatters while the other is stable, including a change on every clock, the number of up strobes equals the number of down strobes once the phase returns to its starting level. No strobe is lost.
- R8: `rst` is synchronous and active high. While it is asserted, and in the first cycle after it is released, `cnt_en` and `step_err` are low. Reset loads the history with the current sampled inputs, so inputs that changed during reset produce no strobe after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| res_sel | input | 2 | Resolution select: 00 = 1x, 01 = 2x, 1x = 4x |
| enc_a | input | 1 | Raw phase A, asynchronous |
| enc_b | input | 1 | Raw phase B, asynchronous |
| cnt_en | output | 1 | One-cycle count-enable strobe |
| cnt_up | output | 1 | Direction for the strobe, 1 = up |
| step_err | output | 1 | One-cycle pulse on a step where both phases changed |

## Verification
For every resolution code, the bench walks all sixteen pairs of (old state, new state). This covers legal steps in both directions, no-change steps and steps where both phases change. It tells apart the cases that count, the cases that must be ignored and the cases that must raise an error.

A chatter burst on A, toggling once per clock, checks that no edge is dropped and that the count nets to zero. A burst on B in 2x checks that B activity is rejected. A reset with the inputs moved under it checks that the history reload suppresses any stale strobe.

// File: rtl/quad_step_decoder.sv
module quad_step_decoder #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] res_sel,
  input  logic       enc_a,
  input  logic       enc_b,
  output logic       cnt_en,
  output logic       cnt_up,
  output logic       step_err
);

  logic [SYNC_STAGES-1:0] a_pipe, b_pipe;
  logic a_now, b_now, a_prev, b_prev;
  logic a_moved, b_moved, qualify, dir;

  always_ff @(posedge clk) begin
    a_pipe <= {a_pipe[SYNC_STAGES-2:0], enc_a};
    b_pipe <= {b_pipe[SYNC_STAGES-2:0], enc_b};
  end

  assign a_now   = a_pipe[SYNC_STAGES-1];
  assign b_now   = b_pipe[SYNC_STAGES-1];
  assign a_moved = a_now ^ a_prev;
  assign b_moved = b_now ^ b_prev;

  always_comb begin
    qualify = 1'b0;
    dir     = 1'b0;
    if (a_moved ^ b_moved) begin
      unique casez (res_sel)
        2'b1?: begin
          qualify = 1'b1;
          dir     = b_prev ^ a_now;
        end
        2'b01: begin
          qualify = a_moved;
          dir     = a_now ^ b_now;
        end
        default: begin
          qualify = a_moved & ~b_now;
          dir     = a_now;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    a_prev <= a_now;
    b_prev <= b_now;
    if (rst) begin
      cnt_en   <= 1'b0;
      cnt_up   <= 1'b0;
      step_err <= 1'b0;
    end else begin
      cnt_en   <= qualify;
      cnt_up   <= qualify ? dir : cnt_up;
      step_err <= a_moved & b_moved;
    end
  end

endmodule

// File: rtl/quad_step_decoder_props.sv
module quad_step_decoder_props (
  input logic       clk,
  input logic       rst,
  input logic [1:0] res_sel,
  input logic       cnt_en,
  input logic       cnt_up,
  input logic       step_err,
  input logic       a_hist,
  input logic       b_hist
);

  AST_EN_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(cnt_en && step_err)); // R6

  AST_ERR_BOTH_MOVED: assert property (@(posedge clk) disable iff (rst)
    step_err |-> (a_hist != $past(a_hist)) && (b_hist != $past(b_hist))); // R6

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !cnt_en && !step_err); // R8

  AST_FULL_RES_DIR: assert property (@(posedge clk) disable iff (rst)
    ($past(res_sel[1]) && cnt_en) |-> cnt_up == ($past(b_hist) ^ a_hist)); // R2

  AST_HALF_RES_DIR: assert property (@(posedge clk) disable iff (rst)
    ($past(res_sel) == 2'b01 && cnt_en) |-> cnt_up == (a_hist ^ b_hist)); // R3

  AST_SINGLE_RES_B_LOW: assert property (@(posedge clk) disable iff (rst)
    ($past(res_sel) == 2'b00 && cnt_en) |-> !b_hist && cnt_up == a_hist); // R4

endmodule

bind quad_step_decoder quad_step_decoder_props u_props (
  .clk(clk), .rst(rst), .res_sel(res_sel), .cnt_en(cnt_en),
  .cnt_up(cnt_up), .step_err(step_err), .a_hist(a_prev), .b_hist(b_prev)
);

// File: tb/quad_step_decoder_test.sv
module quad_step_decoder_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] res_sel = 2'b10;
  logic enc_a = 1'b0, enc_b = 1'b0;
  logic cnt_en, cnt_up, step_err;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic cur_a = 1'b0, cur_b = 1'b0;

  always #10 clk = ~clk;

  quad_step_decoder uut (
    .clk(clk), .rst(rst), .res_sel(res_sel), .enc_a(enc_a), .enc_b(enc_b),
    .cnt_en(cnt_en), .cnt_up(cnt_up), .step_err(step_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] sel);
    @(negedge clk);
    rst = 1'b1;
    res_sel = sel;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  // R1 R2 R3 R4 R5 R6: one step, window of six clocks
  task automatic step(input logic na, input logic nb, input string req);
    int n_en, n_err, n_up;
    bit da, db, exp_en, exp_err, exp_up;
    da = na ^ cur_a;
    db = nb ^ cur_b;
    exp_err = da & db;
    exp_en = 1'b0;
    exp_up = 1'b0;
    if (da ^ db) begin
      if (res_sel[1]) begin
        exp_en = 1'b1; exp_up = cur_b ^ na;
      end else if (res_sel == 2'b01) begin
        exp_en = da; exp_up = na ^ nb;
      end else begin
        exp_en = da & ~nb; exp_up = na;
      end
    end
    @(negedge clk);
    enc_a = na; enc_b = nb;
    n_en = 0; n_err = 0; n_up = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (cnt_en) begin n_en++; if (cnt_up) n_up++; end
      if (step_err) n_err++;
    end
    check(n_en == int'(exp_en), req, "strobe count", n_en, int'(exp_en));
    check(n_err == int'(exp_err), "R6", "error count", n_err, int'(exp_err));
    if (exp_en) check(n_up == int'(exp_up), req, "direction", n_up, int'(exp_up));
    cur_a = na; cur_b = nb;
  endtask

  // R7: toggle a phase every clock, count strobes
  task automatic chatter(input bit on_b, input int toggles, input int exp_events);
    int ups, downs;
    ups = 0; downs = 0;
    fork
      begin
        for (int i = 0; i < toggles; i++) begin
          @(negedge clk);
          if (on_b) enc_b = ~enc_b; else enc_a = ~enc_a;
        end
      end
      begin
        for (int i = 0; i < toggles + 8; i++) begin
          @(negedge clk);
          if (cnt_en) begin if (cnt_up) ups++; else downs++; end
        end
      end
    join
    cur_a = enc_a; cur_b = enc_b;
    check(ups == downs, "R7", "net count", ups - downs, 0);
    check(ups + downs == exp_events, "R7", "strobe total", ups + downs, exp_events);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(cnt_en == 1'b0 && step_err == 1'b0, "R8", "outputs in reset",
          int'({cnt_en, step_err}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(cnt_en == 1'b0 && step_err == 1'b0, "R8", "first cycle after reset",
          int'({cnt_en, step_err}), 0);

    for (int m = 0; m < 4; m++) begin
      do_reset(m[1:0]);
      for (int s = 0; s < 4; s++)
        for (int t = 0; t < 4; t++) begin
          step(s[0], s[1], m == 3 ? "R5" : (m == 2 ? "R2" : (m == 1 ? "R3" : "R4")));
          step(t[0], t[1], m[1] ? "R2" : (m == 1 ? "R3" : "R4"));
        end
    end

    for (int m = 0; m < 3; m++) begin
      do_reset(m[1:0]);
      step(1'b0, 1'b0, "R1");
      chatter(1'b0, 6, 6);
    end
    do_reset(2'b01);
    chatter(1'b1, 6, 0);
    do_reset(2'b00);
    step(1'b0, 1'b1, "R4");
    chatter(1'b0, 4, 0);

    // R8: inputs move during reset
    do_reset(2'b10);
    step(1'b0, 1'b0, "R8");
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    enc_a = 1'b1; enc_b = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cur_a = 1'b1; cur_b = 1'b1;
    begin
      int n = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (cnt_en || step_err) n++;
      end
      check(n == 0, "R8", "pulses after reset release", n, 0);
    end
    step(1'b0, 1'b1, "R2");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule